// File: doc/BRIEF.md
# External Bus Chip-Select Decoder and Arbiter

This block owns the external memory bus of a small system. Three masters (an audio engine, a video engine and the CPU) each present a request line and a 22-bit word address. When the bus is free, the block picks one requester by a fixed priority order chosen in the bus configuration word. It asserts that requester's grant and drives exactly one active-low chip select, worked out from the granted address. It holds both for one cycle plus the configured number of wait states, and pulses `done` in the last cycle of the access.

Decoding has two layers. The first is an optional RAM window. It ends at the top of the address space, its size is a power of two from 4K to 512K words, and it wins over every other select. Below that window, the external space from word 0x4000 upward is served by one, two or four ROM-type selects, depending on the ROM mode. Addresses below 0x4000 belong to on-chip resources, so they are still granted and timed but drive no chip select.

Chip select, grant and wait count are all captured in the cycle the access is granted. Arbitration runs only while the bus is idle, or on the clock edge that ends an access, so back-to-back accesses carry no idle cycle between them.

Top module: `xbus_ctrl`

## Requirements
- R1: While `rst` is high, and on the cycle after it, all grants are 0, all chip selects are 1 and `done` is 0, whatever the requests are.
- R2: A granted address below 0x4000 drives every chip select high, for any configuration.
- R3: With ROM mode `bus_cfg[7:6]`=00 and no RAM hit, every address from 0x4000 to 0x3FFFFF selects `rom_cs_n`.
- R4: With ROM mode 01 and no RAM hit, addresses 0x4000 to 0x1FFFFF select `rom_cs_n` and addresses 0x200000 to 0x3FFFFF select `ext1_cs_n`.
- R5: With ROM mode 10 or 11 and no RAM hit, address bits [21:20] equal to 0, 1, 2 and 3 select `rom_cs_n` (from 0x4000), `ext1_cs_n`, `ext2_cs_n` and `ext3_cs_n` respectively.
- R6: When `bus_cfg[11]`=1, addresses from 0x400000 − (4096 << `bus_cfg[10:8]`) to 0x3FFFFF select `ram_cs_n` ahead of any ROM select, and the address just below that window decodes by the ROM mode. When `bus_cfg[11]`=0, no address selects `ram_cs_n`.
- R7: At most one chip select is low, and a chip select is low only while a grant is high.
- R8: Priority code `bus_cfg[5:3]`=101 grants pending requests in the order audio, video, CPU.
- R9: Priority code 111 grants pending requests in the order video, audio, CPU.
- R10: Every other priority code orders the requests as code 101 does.
- R11: A grant lasts exactly 1 + `bus_cfg[2:1]` cycles. `done` is high in its last cycle only, and if no request is pending at that point, the grant drops on the next edge.
- R12: A grant and its chip select stay unchanged until `done`, even if a higher-priority request arrives. A request pending during the `done` cycle is granted on the very next edge.
- R13: At most one grant is high, and a new grant goes only to a requester that was requesting at the granting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cfg | input | 11 | Bus configuration word, bits [11:1]: [11] RAM window enable, [10:8] RAM size code, [7:6] ROM mode, [5:3] priority code, [2:1] wait states |
| req_aud | input | 1 | Audio engine request |
| addr_aud | input | 22 | Audio engine word address |
| req_vid | input | 1 | Video engine request |
| addr_vid | input | 22 | Video engine word address |
| req_cpu | input | 1 | CPU request |
| addr_cpu | input | 22 | CPU word address |
| gnt_aud | output | 1 | Bus granted to audio |
| gnt_vid | output | 1 | Bus granted to video |
| gnt_cpu | output | 1 | Bus granted to CPU |
| rom_cs_n | output | 1 | ROM select, active low |
| ext1_cs_n | output | 1 | Second ROM-space select, active low |
| ext2_cs_n | output | 1 | Third ROM-space select, active low |
| ext3_cs_n | output | 1 | Fourth ROM-space select, active low |
| ram_cs_n | output | 1 | RAM window select, active low |
| done | output | 1 | High in the last cycle of an access |

## Verification
The properties assume each requester keeps its request and address steady from the moment it raises the request until it sees `done` for its own grant. At that point the requester lowers the request, or leaves it up to ask again. The stimulus follows this contract. Every request and address change is made on a falling edge, and a requester's line is dropped only after the bench has seen `done` while that requester held the grant. The configuration word changes only while no grant is held, so priority and wait settings never change partway through an access they could affect.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int NREQ = 3;
    localparam int NCS  = 5;

    // requester slot indices
    localparam int RQ_AUD = 0;
    localparam int RQ_VID = 1;
    localparam int RQ_CPU = 2;

    localparam logic [2:0] PRIO_VIDEO_FIRST = 3'b111;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ROM,
        SEL_X1,
        SEL_X2,
        SEL_X3,
        SEL_RAM
    } cs_sel_e;

    typedef struct packed {
        logic       ram_en;
        logic [2:0] ram_size;
        logic [1:0] rom_mode;
        logic [2:0] prio;
        logic [1:0] waits;
    } bus_cfg_t;

    function automatic bus_cfg_t unpack_cfg(input logic [11:1] w);
        bus_cfg_t c;
        c.ram_en   = w[11];
        c.ram_size = w[10:8];
        c.rom_mode = w[7:6];
        c.prio     = w[5:3];
        c.waits    = w[2:1];
        return c;
    endfunction

    // active-low selects, bit order {ram, x3, x2, x1, rom}
    function automatic logic [NCS-1:0] sel_to_cs_n(input cs_sel_e s);
        logic [NCS-1:0] v;
        case (s)
            SEL_ROM: v = 5'b11110;
            SEL_X1:  v = 5'b11101;
            SEL_X2:  v = 5'b11011;
            SEL_X3:  v = 5'b10111;
            SEL_RAM: v = 5'b01111;
            default: v = 5'b11111;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/xbus_addr_decode.sv
module xbus_addr_decode
    import xbus_pkg::*;
#(
    parameter int ADDR_W       = 22,
    parameter int EXT_BASE     = 'h4000,
    parameter int RAM_MIN_LOG2 = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  bus_cfg_t          cfg,
    output cs_sel_e           sel
);
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(EXT_BASE);

    logic [ADDR_W-1:0] ram_mask;
    logic              ram_hit;
    logic              is_ext;
    cs_sel_e           rom_sel;

    always_comb begin
        ram_mask = {ADDR_W{1'b1}} << (RAM_MIN_LOG2 + int'(cfg.ram_size));
        ram_hit  = cfg.ram_en && ((addr & ram_mask) == ram_mask);
        is_ext   = (addr >= BASE);
    end

    always_comb begin
        case (cfg.rom_mode)
            2'b00:   rom_sel = SEL_ROM;
            2'b01:   rom_sel = addr[ADDR_W-1] ? SEL_X1 : SEL_ROM;
            default: begin
                case (addr[ADDR_W-1 -: 2])
                    2'd0:    rom_sel = SEL_ROM;
                    2'd1:    rom_sel = SEL_X1;
                    2'd2:    rom_sel = SEL_X2;
                    default: rom_sel = SEL_X3;
                endcase
            end
        endcase
    end

    always_comb begin
        if (!is_ext)      sel = SEL_NONE;
        else if (ram_hit) sel = SEL_RAM;
        else              sel = rom_sel;
    end

endmodule

// File: rtl/xbus_prio_pick.sv
module xbus_prio_pick
    import xbus_pkg::*;
(
    input  logic [NREQ-1:0] req,
    input  logic [2:0]      prio,
    output logic [NREQ-1:0] win,
    output logic            any
);
    int order [NREQ];

    always_comb begin
        order[0] = (prio == PRIO_VIDEO_FIRST) ? RQ_VID : RQ_AUD;
        order[1] = (prio == PRIO_VIDEO_FIRST) ? RQ_AUD : RQ_VID;
        order[2] = RQ_CPU;
    end

    always_comb begin
        logic found;
        found = 1'b0;
        win   = '0;
        for (int r = 0; r < NREQ; r++) begin
            if (!found && req[order[r]]) begin
                win[order[r]] = 1'b1;
                found         = 1'b1;
            end
        end
        any = |req;
    end

endmodule

// File: rtl/xbus_wait_ctr.sv
module xbus_wait_ctr #(
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    output logic              busy,
    output logic              last
);
    logic [WAIT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (load) begin
            busy <= 1'b1;
            cnt  <= load_val;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    assign last = busy && (cnt == '0);

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int ADDR_W       = 22,
    parameter int EXT_BASE     = 'h4000,
    parameter int RAM_MIN_LOG2 = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [11:1]       bus_cfg,
    input  logic              req_aud,
    input  logic [ADDR_W-1:0] addr_aud,
    input  logic              req_vid,
    input  logic [ADDR_W-1:0] addr_vid,
    input  logic              req_cpu,
    input  logic [ADDR_W-1:0] addr_cpu,
    output logic              gnt_aud,
    output logic              gnt_vid,
    output logic              gnt_cpu,
    output logic              rom_cs_n,
    output logic              ext1_cs_n,
    output logic              ext2_cs_n,
    output logic              ext3_cs_n,
    output logic              ram_cs_n,
    output logic              done
);
    localparam int WAIT_W = 2;

    bus_cfg_t          cfg;
    logic [NREQ-1:0]   req_v;
    logic [ADDR_W-1:0] addr_v [NREQ];
    logic [NREQ-1:0]   win;
    logic              any_req;
    logic [ADDR_W-1:0] win_addr;
    cs_sel_e           win_sel;
    logic              busy;
    logic              last;
    logic              start;
    logic [NREQ-1:0]   gnt_q;
    cs_sel_e           sel_q;
    logic [NCS-1:0]    cs_n_v;

    assign cfg = unpack_cfg(bus_cfg);

    assign req_v[RQ_AUD]  = req_aud;
    assign req_v[RQ_VID]  = req_vid;
    assign req_v[RQ_CPU]  = req_cpu;
    assign addr_v[RQ_AUD] = addr_aud;
    assign addr_v[RQ_VID] = addr_vid;
    assign addr_v[RQ_CPU] = addr_cpu;

    xbus_prio_pick u_pick (
        .req  (req_v),
        .prio (cfg.prio),
        .win  (win),
        .any  (any_req)
    );

    // address of the winner, AND-OR mux over the one-hot pick
    always_comb begin
        win_addr = '0;
        for (int i = 0; i < NREQ; i++) begin
            win_addr = win_addr | (addr_v[i] & {ADDR_W{win[i]}});
        end
    end

    xbus_addr_decode #(
        .ADDR_W       (ADDR_W),
        .EXT_BASE     (EXT_BASE),
        .RAM_MIN_LOG2 (RAM_MIN_LOG2)
    ) u_dec (
        .addr (win_addr),
        .cfg  (cfg),
        .sel  (win_sel)
    );

    assign start = any_req && (!busy || last);

    xbus_wait_ctr #(
        .WAIT_W (WAIT_W)
    ) u_wait (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .load_val (cfg.waits),
        .busy     (busy),
        .last     (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_q <= '0;
            sel_q <= SEL_NONE;
        end else if (start) begin
            gnt_q <= win;
            sel_q <= win_sel;
        end else if (last) begin
            gnt_q <= '0;
            sel_q <= SEL_NONE;
        end
    end

    assign cs_n_v = sel_to_cs_n(sel_q);

    assign gnt_aud   = gnt_q[RQ_AUD];
    assign gnt_vid   = gnt_q[RQ_VID];
    assign gnt_cpu   = gnt_q[RQ_CPU];
    assign rom_cs_n  = cs_n_v[0];
    assign ext1_cs_n = cs_n_v[1];
    assign ext2_cs_n = cs_n_v[2];
    assign ext3_cs_n = cs_n_v[3];
    assign ram_cs_n  = cs_n_v[4];
    assign done      = last;

endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic req_aud,
    input logic req_vid,
    input logic req_cpu,
    input logic gnt_aud,
    input logic gnt_vid,
    input logic gnt_cpu,
    input logic rom_cs_n,
    input logic ext1_cs_n,
    input logic ext2_cs_n,
    input logic ext3_cs_n,
    input logic ram_cs_n,
    input logic done
);
    logic [2:0] g;
    logic [2:0] r;
    logic [4:0] cs_n;

    assign g    = {gnt_cpu, gnt_vid, gnt_aud};
    assign r    = {req_cpu, req_vid, req_aud};
    assign cs_n = {ram_cs_n, ext3_cs_n, ext2_cs_n, ext1_cs_n, rom_cs_n};

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (g == 3'b000 && cs_n == 5'b11111 && !done));

    assert_one_grant_R13: assert property (@(posedge clk) disable iff (rst)
        $onehot0(g));

    assert_one_select_R7: assert property (@(posedge clk) disable iff (rst)
        $countones(~cs_n) <= 1);

    assert_select_needs_grant_R7: assert property (@(posedge clk) disable iff (rst)
        (cs_n != 5'b11111) |-> (g != 3'b000));

    assert_done_needs_grant_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> (g != 3'b000));

    assert_release_R11: assert property (@(posedge clk) disable iff (rst)
        (done && r == 3'b000) |=> (g == 3'b000));

    assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (g != 3'b000 && !done) |=> ($stable(g) && $stable(cs_n)));

    assert_grant_to_requester_R13: assert property (@(posedge clk) disable iff (rst)
        ((g == 3'b000 || done) && r != 3'b000) |=> ((g & $past(r)) != 3'b000));

endmodule

bind xbus_ctrl xbus_ctrl_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_aud   (req_aud),
    .req_vid   (req_vid),
    .req_cpu   (req_cpu),
    .gnt_aud   (gnt_aud),
    .gnt_vid   (gnt_vid),
    .gnt_cpu   (gnt_cpu),
    .rom_cs_n  (rom_cs_n),
    .ext1_cs_n (ext1_cs_n),
    .ext2_cs_n (ext2_cs_n),
    .ext3_cs_n (ext3_cs_n),
    .ram_cs_n  (ram_cs_n),
    .done      (done)
);

// File: tb/xbus_ctrl_tb_top.sv
`timescale 1ns/1ps
module xbus_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:1] bus_cfg = '0;
    logic [2:0]  rq = '0;
    logic [21:0] ad [3];
    logic        gnt_aud, gnt_vid, gnt_cpu;
    logic        rom_cs_n, ext1_cs_n, ext2_cs_n, ext3_cs_n, ram_cs_n, done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    xbus_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_cfg   (bus_cfg),
        .req_aud   (rq[0]),
        .addr_aud  (ad[0]),
        .req_vid   (rq[1]),
        .addr_vid  (ad[1]),
        .req_cpu   (rq[2]),
        .addr_cpu  (ad[2]),
        .gnt_aud   (gnt_aud),
        .gnt_vid   (gnt_vid),
        .gnt_cpu   (gnt_cpu),
        .rom_cs_n  (rom_cs_n),
        .ext1_cs_n (ext1_cs_n),
        .ext2_cs_n (ext2_cs_n),
        .ext3_cs_n (ext3_cs_n),
        .ram_cs_n  (ram_cs_n),
        .done      (done)
    );

    // chip-select codes used by the bench: 0 none, 1 rom, 2 ext1, 3 ext2, 4 ext3, 5 ram, 9 several
    localparam int C_NONE = 0, C_ROM = 1, C_X1 = 2, C_X2 = 3, C_X3 = 4, C_RAM = 5;

    function automatic int cs_code();
        logic [4:0] v;
        v = ~{ram_cs_n, ext3_cs_n, ext2_cs_n, ext1_cs_n, rom_cs_n};
        case (v)
            5'b00000: return C_NONE;
            5'b00001: return C_ROM;
            5'b00010: return C_X1;
            5'b00100: return C_X2;
            5'b01000: return C_X3;
            5'b10000: return C_RAM;
            default:  return 9;
        endcase
    endfunction

    function automatic logic [2:0] gv();
        return {gnt_cpu, gnt_vid, gnt_aud};
    endfunction

    function automatic logic [11:1] mk_cfg(input logic ram_en, input logic [2:0] rsz,
                                           input logic [1:0] rom, input logic [2:0] pr,
                                           input logic [1:0] w);
        return {ram_en, rsz, rom, pr, w};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one access by requester who, checks select code and held length
    task automatic run_one(input int who, input logic [21:0] a, input int exp_cs,
                           input int exp_len, input string tag);
        int len;
        int seen_cs;
        len = 0;
        seen_cs = -1;
        @(negedge clk);
        ad[who] = a;
        rq[who] = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (gv()[who]) begin
                if (len == 0) seen_cs = cs_code();
                len++;
                if (done) begin
                    rq[who] = 1'b0;
                    break;
                end
            end
        end
        chk(seen_cs == exp_cs, {tag, " select"}, seen_cs, exp_cs);
        chk(len == exp_len, {tag, " length"}, len, exp_len);
        @(negedge clk);
        chk(gv() == 3'b000, {tag, " release R11"}, gv(), 0);
    endtask

    task automatic t_reset();
        rq = 3'b111;
        ad[0] = 22'h004000; ad[1] = 22'h004000; ad[2] = 22'h004000;
        repeat (3) @(negedge clk);
        chk(gv() == 3'b000 && cs_code() == C_NONE && !done, "R1 during reset",
            {gv(), 5'(cs_code())}, 0);
        @(negedge clk);
        rq = 3'b000;
        rst = 1'b0;
        @(negedge clk);
        chk(gv() == 3'b000 && cs_code() == C_NONE && !done, "R1 after reset",
            {gv(), 5'(cs_code())}, 0);
    endtask

    task automatic t_rom_modes();
        bus_cfg = mk_cfg(1'b0, 3'd7, 2'b00, 3'b101, 2'd0);
        run_one(2, 22'h004000, C_ROM, 1, "R3 base");
        run_one(2, 22'h3FFFFF, C_ROM, 1, "R3 top");
        run_one(0, 22'h003FFF, C_NONE, 1, "R2 below base mode00");
        bus_cfg = mk_cfg(1'b0, 3'd0, 2'b01, 3'b101, 2'd0);
        run_one(1, 22'h1FFFFF, C_ROM, 1, "R4 lower half");
        run_one(1, 22'h200000, C_X1, 1, "R4 upper half");
        run_one(1, 22'h000010, C_NONE, 1, "R2 below base mode01");
        bus_cfg = mk_cfg(1'b0, 3'd0, 2'b10, 3'b101, 2'd0);
        run_one(2, 22'h0FFFFF, C_ROM, 1, "R5 q0");
        run_one(2, 22'h100000, C_X1, 1, "R5 q1");
        run_one(2, 22'h2ABCDE, C_X2, 1, "R5 q2");
        run_one(2, 22'h3FFFFF, C_X3, 1, "R5 q3");
        bus_cfg = mk_cfg(1'b0, 3'd0, 2'b11, 3'b101, 2'd0);
        run_one(0, 22'h1F0000, C_X1, 1, "R5 mode11 q1");
        run_one(0, 22'h300000, C_X3, 1, "R5 mode11 q3");
    endtask

    task automatic t_ram_window();
        for (int s = 0; s < 8; s++) begin
            logic [21:0] lo;
            lo = 22'(32'h400000 - (32'd4096 << s));
            bus_cfg = mk_cfg(1'b1, 3'(s), 2'b10, 3'b101, 2'd0);
            run_one(2, lo, C_RAM, 1, $sformatf("R6 size%0d bottom", s));
            run_one(2, lo - 22'd1, C_X3, 1, $sformatf("R6 size%0d below", s));
        end
        bus_cfg = mk_cfg(1'b1, 3'd7, 2'b00, 3'b101, 2'd0);
        run_one(1, 22'h3FFFFF, C_RAM, 1, "R6 top mode00");
        run_one(1, 22'h001000, C_NONE, 1, "R2 below base ram on");
        bus_cfg = mk_cfg(1'b0, 3'd7, 2'b00, 3'b101, 2'd0);
        run_one(1, 22'h3FFFFF, C_ROM, 1, "R6 window disabled");
    endtask

    task automatic t_waits();
        for (int w = 0; w < 4; w++) begin
            bus_cfg = mk_cfg(1'b0, 3'd0, 2'b01, 3'b101, 2'(w));
            run_one(w % 3, 22'h250000, C_X1, 1 + w, $sformatf("R11 waits%0d", w));
        end
    endtask

    // all three request together; record grant order
    task automatic t_prio(input logic [2:0] code, input int e0, input int e1, input int e2,
                          input string tag);
        int got [3];
        int n;
        n = 0;
        bus_cfg = mk_cfg(1'b0, 3'd0, 2'b00, code, 2'd1);
        @(negedge clk);
        ad[0] = 22'h010000; ad[1] = 22'h020000; ad[2] = 22'h030000;
        rq = 3'b111;
        for (int k = 0; k < 30 && n < 3; k++) begin
            @(negedge clk);
            if (done) begin
                for (int i = 0; i < 3; i++) begin
                    if (gv()[i]) begin
                        got[n] = i;
                        rq[i] = 1'b0;
                    end
                end
                n++;
            end
        end
        chk(n == 3 && got[0] == e0 && got[1] == e1 && got[2] == e2, tag,
            (got[0] << 8) | (got[1] << 4) | got[2], (e0 << 8) | (e1 << 4) | e2);
        @(negedge clk);
        chk(gv() == 3'b000, {tag, " idle"}, gv(), 0);
    endtask

    task automatic t_no_preempt();
        bit held;
        int later;
        held = 1'b1;
        later = -1;
        bus_cfg = mk_cfg(1'b0, 3'd0, 2'b00, 3'b101, 2'd3);
        @(negedge clk);
        ad[2] = 22'h008000;
        rq[2] = 1'b1;
        @(negedge clk);
        ad[0] = 22'h3F0000;
        rq[0] = 1'b1;
        for (int k = 0; k < 10; k++) begin
            if (gv() != 3'b100 || cs_code() != C_ROM) held = 1'b0;
            if (done) begin
                rq[2] = 1'b0;
                break;
            end
            @(negedge clk);
        end
        chk(held, "R12 cpu keeps bus", held, 1);
        @(negedge clk);
        later = int'(gv());
        chk(later == 3'b001, "R12 audio next edge", later, 3'b001);
        for (int k = 0; k < 10; k++) begin
            if (done) begin
                rq[0] = 1'b0;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        chk(gv() == 3'b000, "R12 idle after audio", gv(), 0);
    endtask

    initial begin
        ad[0] = '0; ad[1] = '0; ad[2] = '0;
        t_reset();
        t_rom_modes();
        t_ram_window();
        t_waits();
        t_prio(3'b101, 0, 1, 2, "R8 order audio-video-cpu");
        t_prio(3'b111, 1, 0, 2, "R9 order video-audio-cpu");
        t_prio(3'b000, 0, 1, 2, "R10 code000");
        t_prio(3'b110, 0, 1, 2, "R10 code110");
        t_no_preempt();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule